// File: doc/BRIEF.md
# Redundant Reference Switchover Controller

This block chooses which of two redundant reference clocks, A or B, feeds a downstream phase-locked loop. Each raw reference first goes through its own integer divider, clocked by that reference. A presence monitor then watches each divided reference from a free-running local clock. It synchronizes the divided signal and judges it present or lost against a programmable window of local cycles.

A small state machine combines the two presence flags with a mode setting to produce the selected-reference indicator. The mode is manual, automatic non-revertive or automatic revertive. In manual mode the selection comes from a register bit or from an external pin. When both references are gone, the machine enters holdover and drives the charge-pump control to tristate, or to midscale if configured. It leaves holdover as soon as a reference comes back.

Top module: `refsel_ctrl`

## Requirements
- R1: Each divider produces one rising edge per N rising edges of its raw reference, with N set by a 10-bit ratio from 2 to 1023. A ratio of 0 or 1 passes the raw reference through. Presence is judged on the divided signal only.
- R2: A reference is reported present (present_a/present_b = 1) within four local cycles after a divided rising edge. It is reported lost once win_len local cycles pass with no divided rising edge.
- R3: After reset, active_ref = 0, holdover = 1, cp_mode = 01 and both present flags are 0. The encoding of active_ref is 0 for reference A and 1 for reference B.
- R4: In the automatic modes, the selection moves from A to B only when A is lost and B is present. It never leaves A while A is present.
- R5: In non-revertive mode (mode = 01), the selection stays on B after A returns. It goes back to A only when B is lost and A is present.
- R6: In revertive mode (mode = 10, and also 11), the selection returns to A in the cycle after A is seen present.
- R7: In every mode, the block enters holdover (holdover = 1) in the cycle after both references are absent. It leaves holdover once a reference is present. In the automatic modes it then takes A if A is present, and otherwise B.
- R8: cp_mode is 00 (normal) outside holdover. During holdover it is 01 (tristate) when cp_mid_en = 0 and 10 (midscale) when cp_mid_en = 1.
- R9: In manual mode (mode = 00), the selection is ref_sel_pin when man_src_pin = 1 and man_sel_reg otherwise. The new selection appears on active_ref at the next local clock edge, without regard to presence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a_clk | input | 1 | Raw reference A |
| ref_b_clk | input | 1 | Raw reference B |
| div_a | input | 10 | Divide ratio for reference A |
| div_b | input | 10 | Divide ratio for reference B |
| win_len | input | 16 | Presence window in local cycles |
| mode | input | 2 | 00 manual, 01 non-revertive, 10/11 revertive |
| man_sel_reg | input | 1 | Manual selection from register |
| man_src_pin | input | 1 | 1 = manual selection taken from ref_sel_pin |
| ref_sel_pin | input | 1 | Manual selection from external pin |
| cp_mid_en | input | 1 | 1 = midscale charge pump in holdover |
| active_ref | output | 1 | Selected reference, 0 = A, 1 = B |
| holdover | output | 1 | Both references lost |
| cp_mode | output | 2 | 00 normal, 01 tristate, 10 midscale |
| present_a | output | 1 | Reference A present |
| present_b | output | 1 | Reference B present |

## Verification
On every cycle, the assertions check four things against the presence flags of the previous cycle: that manual mode tracks the chosen select source, that automatic modes never leave a present A for B, that non-revertive mode holds on a present B, and that revertive mode returns to a present A. They also check that both references being absent forces holdover, and that a synchronized edge always raises the present flag. Only the bench scenarios can show the end-to-end timing of loss and recovery through the dividers and the window, and the effect of a large divide ratio on when presence first appears. The same applies to the pass-through behaviour for ratios 0 and 1, and to the complete switch sequences that compare the three automatic modes side by side.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    MODE_MANUAL  = 2'b00,
    MODE_NONREV  = 2'b01,
    MODE_REV     = 2'b10,
    MODE_REV_ALT = 2'b11
  } sw_mode_e;

  typedef enum logic [1:0] {
    CP_NORMAL   = 2'b00,
    CP_TRISTATE = 2'b01,
    CP_MIDSCALE = 2'b10
  } cp_mode_e;

  localparam logic SEL_A = 1'b0;
  localparam logic SEL_B = 1'b1;
endpackage

// File: rtl/refsel_divider.sv
module refsel_divider #(
  parameter int DIV_W = 10
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio,
  output logic             div_out
);
  logic [DIV_W-1:0] cnt_q, cnt_d, last_cnt;
  logic             pulse_q, pulse_d;
  logic             bypass;

  always_comb begin
    bypass   = (ratio <= DIV_W'(1));
    last_cnt = bypass ? '0 : ratio - DIV_W'(1);
    cnt_d    = (cnt_q >= last_cnt) ? '0 : cnt_q + DIV_W'(1);
    pulse_d  = (cnt_d == '0);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  // ratios 0 and 1 pass the raw reference straight through
  assign div_out = bypass ? ref_clk : pulse_q;
endmodule

// File: rtl/refsel_monitor.sv
module refsel_monitor #(
  parameter int WIN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_div,
  input  logic [WIN_W-1:0] win_len,
  output logic             present
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 edge_seen;
  logic [WIN_W-1:0]     age_q, age_d;
  logic                 age_en;
  logic                 pres_q, pres_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ref_div};
  end

  assign edge_seen = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_comb begin
    age_d  = age_q;
    pres_d = pres_q;
    age_en = 1'b1;
    if (edge_seen) begin
      age_d  = '0;
      pres_d = 1'b1;
    end else if ((age_q + WIN_W'(1)) >= win_len) begin
      pres_d = 1'b0;
      age_en = 1'b0;
    end else begin
      age_d  = age_q + WIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      pres_q <= 1'b0;
    end else begin
      if (age_en) age_q <= age_d;
      pres_q <= pres_d;
    end
  end

  assign present = pres_q;

  // R2
  edge_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> present);
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       man_sel_reg,
  input  logic       man_src_pin,
  input  logic       ref_sel_pin,
  input  logic       pres_a,
  input  logic       pres_b,
  input  logic       cp_mid_en,
  output logic       active_ref,
  output logic       holdover,
  output logic [1:0] cp_mode
);
  logic sel_q, sel_d;
  logic hold_q, hold_d;
  logic man_pick;
  logic is_manual, is_rev;
  logic past_ok_q;

  always_comb begin
    man_pick  = man_src_pin ? ref_sel_pin : man_sel_reg;
    is_manual = (mode == MODE_MANUAL);
    is_rev    = (mode == MODE_REV) || (mode == MODE_REV_ALT);
    sel_d     = sel_q;
    hold_d    = hold_q;
    if (is_manual) begin
      sel_d  = man_pick;
      hold_d = !pres_a && !pres_b;
    end else if (!pres_a && !pres_b) begin
      hold_d = 1'b1;
    end else if (hold_q) begin
      hold_d = 1'b0;
      sel_d  = pres_a ? SEL_A : SEL_B;
    end else if (sel_q == SEL_A) begin
      if (!pres_a) sel_d = SEL_B;
    end else begin
      if (!pres_b || (is_rev && pres_a)) sel_d = SEL_A;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= SEL_A;
      hold_q    <= 1'b1;
      past_ok_q <= 1'b0;
    end else begin
      sel_q     <= sel_d;
      hold_q    <= hold_d;
      past_ok_q <= 1'b1;
    end
  end

  always_comb begin
    if (!hold_q)        cp_mode = CP_NORMAL;
    else if (cp_mid_en) cp_mode = CP_MIDSCALE;
    else                cp_mode = CP_TRISTATE;
  end

  assign active_ref = sel_q;
  assign holdover   = hold_q;

  // R9
  man_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q && $past(is_manual) |-> sel_q == $past(man_pick));
  // R4
  auto_stay_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q && $past(!is_manual && !hold_q && sel_q == SEL_A && pres_a) |-> sel_q == SEL_A);
  // R5
  nonrev_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q && $past(mode == MODE_NONREV && !hold_q && sel_q == SEL_B && pres_b) |-> sel_q == SEL_B);
  // R6
  revert_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q && $past(is_rev && pres_a) |-> sel_q == SEL_A && !hold_q);
  // R7
  both_lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q && $past(!pres_a && !pres_b) |-> hold_q);
  // R8
  cp_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> cp_mode != CP_NORMAL);
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl #(
  parameter int DIV_W       = 10,
  parameter int WIN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_a_clk,
  input  logic             ref_b_clk,
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_b,
  input  logic [WIN_W-1:0] win_len,
  input  logic [1:0]       mode,
  input  logic             man_sel_reg,
  input  logic             man_src_pin,
  input  logic             ref_sel_pin,
  input  logic             cp_mid_en,
  output logic             active_ref,
  output logic             holdover,
  output logic [1:0]       cp_mode,
  output logic             present_a,
  output logic             present_b
);
  localparam int NREF = 2;

  logic [NREF-1:0]  raw_ref;
  logic [DIV_W-1:0] ratio [NREF];
  logic [NREF-1:0]  div_ref;
  logic [NREF-1:0]  pres;

  assign raw_ref  = {ref_b_clk, ref_a_clk};
  assign ratio[0] = div_a;
  assign ratio[1] = div_b;

  for (genvar g = 0; g < NREF; g++) begin : g_chan
    refsel_divider #(.DIV_W(DIV_W)) u_div (
      .ref_clk (raw_ref[g]),
      .rst_n   (rst_n),
      .ratio   (ratio[g]),
      .div_out (div_ref[g])
    );
    refsel_monitor #(.WIN_W(WIN_W), .SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_div (div_ref[g]),
      .win_len (win_len),
      .present (pres[g])
    );
  end

  refsel_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .man_sel_reg (man_sel_reg),
    .man_src_pin (man_src_pin),
    .ref_sel_pin (ref_sel_pin),
    .pres_a      (pres[0]),
    .pres_b      (pres[1]),
    .cp_mid_en   (cp_mid_en),
    .active_ref  (active_ref),
    .holdover    (holdover),
    .cp_mode     (cp_mode)
  );

  assign present_a = pres[0];
  assign present_b = pres[1];
endmodule

// File: tb/tb_refsel_ctrl.sv
`timescale 1ns/100ps
module tb_refsel_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_a_clk = 1'b0, ref_b_clk = 1'b0;
  logic       a_on, b_on;
  logic [9:0] div_a, div_b;
  logic [15:0] win_len;
  logic [1:0] mode;
  logic       man_sel_reg, man_src_pin, ref_sel_pin, cp_mid_en;
  logic       active_ref, holdover, present_a, present_b;
  logic [1:0] cp_mode;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  refsel_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_a_clk(ref_a_clk), .ref_b_clk(ref_b_clk),
    .div_a(div_a), .div_b(div_b), .win_len(win_len), .mode(mode),
    .man_sel_reg(man_sel_reg), .man_src_pin(man_src_pin), .ref_sel_pin(ref_sel_pin),
    .cp_mid_en(cp_mid_en), .active_ref(active_ref), .holdover(holdover),
    .cp_mode(cp_mode), .present_a(present_a), .present_b(present_b)
  );

  always #5 clk = ~clk;
  always begin #3.3; if (a_on) ref_a_clk = ~ref_a_clk; end
  always begin #6.7; if (b_on) ref_b_clk = ~ref_b_clk; end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    a_on = 1'b0; b_on = 1'b0;
    div_a = 10'd4; div_b = 10'd4; win_len = 16'd16;
    mode = 2'b01; man_sel_reg = 1'b0; man_src_pin = 1'b0; ref_sel_pin = 1'b0;
    cp_mid_en = 1'b0;
    rst_n = 1'b0;
    cyc(3);
    // R3 reset state
    chk("R3 active_ref", active_ref, 0);
    chk("R3 holdover", holdover, 1);
    chk("R3 cp_mode", cp_mode, 1);
    chk("R3 present_a", present_a, 0);
    chk("R3 present_b", present_b, 0);
    rst_n = 1'b1;
    cyc(2);

    // R7 both come up together: A preferred
    a_on = 1'b1; b_on = 1'b1;
    cyc(60);
    chk("R2 present_a", present_a, 1);
    chk("R2 present_b", present_b, 1);
    chk("R7 leave holdover", holdover, 0);
    chk("R7 prefer A", active_ref, 0);
    chk("R8 normal cp", cp_mode, 0);

    // sweep the three automatic encodings
    for (int m = 1; m <= 3; m++) begin
      mode = 2'(m);
      cyc(5);
      a_on = 1'b0;
      cyc(60);
      chk("R2 A lost", present_a, 0);
      chk("R4 A->B on loss", active_ref, 1);
      a_on = 1'b1;
      cyc(60);
      if (m == 1) chk("R5 stay on B", active_ref, 1);
      else        chk("R6 revert to A", active_ref, 0);
      if (m == 1) begin
        b_on = 1'b0;
        cyc(60);
        chk("R5 back to A on B loss", active_ref, 0);
        b_on = 1'b1;
        cyc(60);
        chk("R5 stay on A after B returns", active_ref, 0);
      end
      // R4: B loss while on A never moves
      b_on = 1'b0;
      cyc(60);
      chk("R4 stay on present A", active_ref, 0);
      b_on = 1'b1;
      cyc(60);
    end

    // R7 / R8 holdover
    mode = 2'b10;
    a_on = 1'b0; b_on = 1'b0;
    cyc(60);
    chk("R7 enter holdover", holdover, 1);
    chk("R8 tristate", cp_mode, 1);
    cp_mid_en = 1'b1;
    cyc(1);
    chk("R8 midscale", cp_mode, 2);
    b_on = 1'b1;
    cyc(60);
    chk("R7 resume on B", active_ref, 1);
    chk("R7 holdover cleared", holdover, 0);
    chk("R8 normal after holdover", cp_mode, 0);
    a_on = 1'b1;
    cyc(60);
    chk("R6 revert after holdover", active_ref, 0);
    cp_mid_en = 1'b0;

    // R9 manual sweep over source and value
    mode = 2'b00;
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 2; v++) begin
        man_src_pin = s[0];
        man_sel_reg = s[0] ? ~v[0] : v[0];
        ref_sel_pin = s[0] ? v[0] : ~v[0];
        cyc(1);
        chk("R9 manual next edge", active_ref, v);
      end
    end
    // R9 no presence check
    b_on = 1'b0;
    cyc(60);
    man_src_pin = 1'b1; ref_sel_pin = 1'b1;
    cyc(1);
    chk("R9 select absent B", active_ref, 1);
    chk("R9 no holdover", holdover, 0);

    // R1 large ratio delays first presence
    mode = 2'b01; b_on = 1'b0; a_on = 1'b1;
    div_a = 10'd600; win_len = 16'd100;
    do_reset();
    cyc(300);
    chk("R1 ratio 600 not yet", present_a, 0);
    cyc(120);
    chk("R1 ratio 600 edge", present_a, 1);
    chk("R7 leave on A", holdover, 0);

    // R1 pass-through ratios
    for (int r = 0; r < 2; r++) begin
      div_a = 10'(r); win_len = 16'd16;
      do_reset();
      cyc(20);
      chk("R1 bypass ratio", present_a, 1);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule